// File: doc/BRIEF.md
# Four-Phase Accumulator Microcontroller Core

An 8-bit microcontroller core built around a single accumulator. It has two parts. A control unit sequences every instruction through four clock phases and handles the interrupt lines. A datapath holds the program counter, the address register, the instruction register, an operand register, the ALU, the flags, a small data RAM and the program ROM. The program ROM is a read-only array. Its whole contents arrive as one packed parameter, 16 bits per word, with word 0 in the lowest bits. With the default value every word is zero, so the core executes NOP forever.

Each instruction word holds a 5-bit opcode in bits 15:11 and an 8-bit operand in bits 7:0. Bits 10:8 are ignored. The operand is used in one of four ways: as an immediate value, as a data RAM address, as a jump target, or as an output-register number.

The core samples one 8-bit input port. It writes a set of 8-bit output registers, which are presented together on one flattened output bus. It accepts four level-sensitive interrupt request lines.

Top module: `mcu_core`

## Requirements
- R1: Every instruction takes exactly four clock cycles, in this order: fetch, decode, operand read, execute. The first rising edge with `rst_n` high performs fetch. The result of the k-th executed instruction (k counted from 0) becomes visible after rising edge 4(k+1), and not before.
- R2: While `rst_n` is low at a rising edge, the core resets. The program counter becomes 0, the accumulator, flags and all output registers become 0, and interrupts become enabled.
- R3: The data transfer opcodes behave as follows. LDI (1) loads the operand into the accumulator. LDA (2) loads RAM[operand] into the accumulator. STA (3) stores the accumulator into RAM[operand]. IN (20) loads `in_port` into the accumulator. OUT (21) copies the accumulator into output register number operand; register n drives `out_ports[8n+7:8n]`. None of these opcodes changes the flags. NOP (0) and the unused codes 23 to 31 change nothing.
- R4: The arithmetic opcodes are ADDI (4), ADD (5), SUBI (6) and SUB (7); the "I" forms take the operand itself, the others take RAM[operand]. The result wraps to 8 bits. After ADD, carry is the carry-out. After SUB, carry is set when a borrow occurs. Zero is set when the 8-bit result is 0.
- R5: The logic opcodes are ANDI (8), AND (9), ORI (10), OR (11), XORI (12), XOR (13), and NOT (14), which inverts the accumulator. Each logic opcode clears carry and sets zero from its result.
- R6: JMP (15) always loads the operand into the program counter. JZ (16), JNZ (17), JC (18) and JNC (19) load it only when their flag condition holds. Otherwise execution continues with the next word.
- R7: Interrupt lines are sampled only in the execute cycle. When interrupts are enabled and any line is high, the lowest-numbered line wins (line 0 has top priority). The return address is saved and execution continues at 0x30 + 4·n, where n is the winning line.
- R8: Taking an interrupt disables further interrupts, so a line held high does not re-enter its own routine. RETI (22) restores the saved program counter and enables interrupts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_port | input | 8 | Input port read by IN |
| irq | input | 4 | Interrupt request lines, level sensitive, line 0 highest |
| out_ports | output | 16 | Output registers 0 and 1, register n in bits 8n+7:8n |

## Verification
The bench counts rising edges from the first edge after reset release. It knows that the result of executed instruction k is due after edge 4(k+1). Each table row names such an instruction index and samples both output registers on the falling edge that follows. One extra check, one cycle early, confirms that a result does not appear before its fourth edge.

Interrupt entry depends on where in the four-phase cycle a request arrives. The interrupt checks therefore wait, on falling edges and with a bound, for the routine's OUT to change output register 1. An OUT at a vector is due eight edges after the execute edge that took the interrupt. The bench drops each request line as soon as the routine's OUT is seen, which is before that routine's RETI executes.

// File: rtl/mcu_pkg.sv
// Shared types for the accumulator core: phase encoding, opcodes, ALU functions.
// Assumes a 5-bit opcode field; codes beyond OP_RETI are treated as no-ops.
package mcu_pkg;
    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_OPER   = 2'd2,
        PH_EXEC   = 2'd3
    } phase_t;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,  OP_LDI  = 5'd1,  OP_LDA  = 5'd2,  OP_STA  = 5'd3,
        OP_ADDI = 5'd4,  OP_ADD  = 5'd5,  OP_SUBI = 5'd6,  OP_SUB  = 5'd7,
        OP_ANDI = 5'd8,  OP_AND  = 5'd9,  OP_ORI  = 5'd10, OP_OR   = 5'd11,
        OP_XORI = 5'd12, OP_XOR  = 5'd13, OP_NOT  = 5'd14, OP_JMP  = 5'd15,
        OP_JZ   = 5'd16, OP_JNZ  = 5'd17, OP_JC   = 5'd18, OP_JNC  = 5'd19,
        OP_IN   = 5'd20, OP_OUT  = 5'd21, OP_RETI = 5'd22
    } op_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT
    } alu_fn_t;
endpackage

// File: rtl/mcu_alu.sv
// Combinational ALU for the accumulator core.
// Carry output: carry-out for add, borrow for subtract, zero for logic ops.
module mcu_alu
    import mcu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_fn_t      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         cy
);
    // Select the operation; add/sub use one extra bit for carry or borrow.
    always_comb begin
        cy = 1'b0;
        y  = '0;
        case (fn)
            ALU_ADD: {cy, y} = {1'b0, a} + {1'b0, b};
            ALU_SUB: {cy, y} = {1'b0, a} - {1'b0, b};
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOT: y = ~a;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/mcu_ctrl.sv
// Control unit: free-running four-phase sequencer plus interrupt arbitration.
// Assumes interrupt lines are synchronous to clk and level sensitive.
module mcu_ctrl
    import mcu_pkg::*;
#(
    parameter int NIRQ = 4,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  op_t             op,
    input  logic [NIRQ-1:0] irq,
    output phase_t          phase,
    output logic            take,
    output logic [IW-1:0]   take_idx,
    output logic            ie
);
    // Fixed priority: the lowest-numbered active line wins.
    always_comb begin
        take_idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq[i]) take_idx = IW'(i);
        end
    end

    assign take = (phase == PH_EXEC) && ie && (|irq);

    // Advance the phase every cycle and track the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
            ie    <= 1'b1;
        end else begin
            phase <= phase_t'(phase + 2'd1);
            if (take) ie <= 1'b0;
            else if (phase == PH_EXEC && op == OP_RETI) ie <= 1'b1;
        end
    end

    // R1: an execute cycle is always followed by a fetch cycle.
    a_r1_exec_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));
    // R8: entering an interrupt leaves interrupts disabled.
    a_r8_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ie);
    // R8: RETI enables interrupts again.
    a_r8_reti_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op == OP_RETI && !take) |=> ie);
endmodule

// File: rtl/mcu_datapath.sv
// Datapath: PC, address register, instruction fields, operand register,
// accumulator, flags, data RAM, program ROM (parameter image) and output registers.
// Assumes the phase and interrupt decisions come from mcu_ctrl.
module mcu_datapath
    import mcu_pkg::*;
#(
    parameter int W          = 8,
    parameter int ROM_DEPTH  = 64,
    parameter int RAM_DEPTH  = 32,
    parameter int NOUT       = 2,
    parameter int NIRQ       = 4,
    parameter int VEC_BASE   = 48,
    parameter int VEC_STRIDE = 4,
    parameter logic [ROM_DEPTH*16-1:0] ROM_IMAGE = '0,
    localparam int RAW = $clog2(ROM_DEPTH),
    localparam int DAW = $clog2(RAM_DEPTH),
    localparam int OSW = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase,
    input  logic            take,
    input  logic [IW-1:0]   take_idx,
    input  logic [W-1:0]    in_port,
    output op_t             ir_op,
    output logic [NOUT*W-1:0] out_ports
);
    logic [W-1:0]   pc, saved_pc, acc, mdr, ir_arg, nxt_pc, b_val, alu_y;
    logic [RAW-1:0] mar;
    logic           zf, cf, alu_cy, is_alu, use_imm;
    alu_fn_t        fn;
    logic [W-1:0]   ram   [RAM_DEPTH];
    logic [W-1:0]   out_q [NOUT];
    logic [4:0]     rom_op;
    logic [W-1:0]   rom_arg;

    // Read the opcode and operand fields of the addressed ROM word.
    assign rom_op  = ROM_IMAGE[int'(mar)*16 + 11 +: 5];
    assign rom_arg = ROM_IMAGE[int'(mar)*16 +: W];

    // Decode ALU function and operand source from the opcode.
    always_comb begin
        is_alu  = 1'b1;
        use_imm = 1'b0;
        fn      = ALU_ADD;
        case (ir_op)
            OP_ADDI: begin fn = ALU_ADD; use_imm = 1'b1; end
            OP_ADD:  fn = ALU_ADD;
            OP_SUBI: begin fn = ALU_SUB; use_imm = 1'b1; end
            OP_SUB:  fn = ALU_SUB;
            OP_ANDI: begin fn = ALU_AND; use_imm = 1'b1; end
            OP_AND:  fn = ALU_AND;
            OP_ORI:  begin fn = ALU_OR;  use_imm = 1'b1; end
            OP_OR:   fn = ALU_OR;
            OP_XORI: begin fn = ALU_XOR; use_imm = 1'b1; end
            OP_XOR:  fn = ALU_XOR;
            OP_NOT:  fn = ALU_NOT;
            default: is_alu = 1'b0;
        endcase
    end

    assign b_val = use_imm ? ir_arg : mdr;

    mcu_alu #(.W(W)) u_alu (.fn(fn), .a(acc), .b(b_val), .y(alu_y), .cy(alu_cy));

    // Choose the program counter that follows this instruction.
    always_comb begin
        nxt_pc = pc;
        case (ir_op)
            OP_JMP:  nxt_pc = ir_arg;
            OP_JZ:   if (zf)  nxt_pc = ir_arg;
            OP_JNZ:  if (!zf) nxt_pc = ir_arg;
            OP_JC:   if (cf)  nxt_pc = ir_arg;
            OP_JNC:  if (!cf) nxt_pc = ir_arg;
            OP_RETI: nxt_pc = saved_pc;
            default: ;
        endcase
    end

    // Perform the work of each phase on the architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; saved_pc <= '0; mar <= '0; mdr <= '0;
            ir_op <= OP_NOP; ir_arg <= '0; acc <= '0; zf <= 1'b0; cf <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH:  mar <= pc[RAW-1:0];
                PH_DECODE: begin
                    ir_op  <= op_t'(rom_op);
                    ir_arg <= rom_arg;
                    pc     <= pc + 1'b1;
                end
                PH_OPER:   mdr <= ram[ir_arg[DAW-1:0]];
                PH_EXEC: begin
                    case (ir_op)
                        OP_LDI: acc <= ir_arg;
                        OP_LDA: acc <= mdr;
                        OP_IN:  acc <= in_port;
                        default: if (is_alu) begin
                            acc <= alu_y;
                            zf  <= (alu_y == '0);
                            cf  <= alu_cy;
                        end
                    endcase
                    if (take) begin
                        saved_pc <= nxt_pc;
                        pc       <= W'(VEC_BASE + VEC_STRIDE * int'(take_idx));
                    end else begin
                        pc <= nxt_pc;
                    end
                end
                default: ;
            endcase
        end
    end

    // Data RAM write port, used by STA in the execute phase.
    always_ff @(posedge clk) begin
        if (phase == PH_EXEC && ir_op == OP_STA) ram[ir_arg[DAW-1:0]] <= acc;
    end

    // Output registers, written by OUT in the execute phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NOUT; i++) out_q[i] <= '0;
        end else if (phase == PH_EXEC && ir_op == OP_OUT) begin
            out_q[ir_arg[OSW-1:0]] <= acc;
        end
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        assign out_ports[g*W +: W] = out_q[g];
    end

    // R1: the PC moves only in decode and execute.
    a_r1_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH || phase == PH_OPER) |=> $stable(pc));
    // R3: outputs change only on an executed OUT.
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase == PH_EXEC && ir_op == OP_OUT) |=> $stable(out_ports));
    // R6: an unconditional jump lands on its operand.
    a_r6_jmp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OP_JMP && !take) |=> (pc == $past(ir_arg)));
    // R7: an interrupt lands inside the vector area.
    a_r7_vector_area: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((pc - W'(VEC_BASE)) < W'(NIRQ * VEC_STRIDE)));
    // R8: RETI returns to the saved address.
    a_r8_reti_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OP_RETI && !take) |=> (pc == $past(saved_pc)));
endmodule

// File: rtl/mcu_core.sv
// Top of the accumulator microcontroller: joins control unit and datapath.
// Assumes synchronous inputs; program image supplied by parameter.
module mcu_core
    import mcu_pkg::*;
#(
    parameter int W          = 8,
    parameter int ROM_DEPTH  = 64,
    parameter int RAM_DEPTH  = 32,
    parameter int NOUT       = 2,
    parameter int NIRQ       = 4,
    parameter int VEC_BASE   = 48,
    parameter int VEC_STRIDE = 4,
    parameter logic [ROM_DEPTH*16-1:0] ROM_IMAGE = '0,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      in_port,
    input  logic [NIRQ-1:0]   irq,
    output logic [NOUT*W-1:0] out_ports
);
    phase_t        phase;
    op_t           ir_op;
    logic          take, ie;
    logic [IW-1:0] take_idx;

    mcu_ctrl #(.NIRQ(NIRQ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(ir_op), .irq(irq),
        .phase(phase), .take(take), .take_idx(take_idx), .ie(ie)
    );

    mcu_datapath #(
        .W(W), .ROM_DEPTH(ROM_DEPTH), .RAM_DEPTH(RAM_DEPTH), .NOUT(NOUT),
        .NIRQ(NIRQ), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
        .ROM_IMAGE(ROM_IMAGE)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .take(take),
        .take_idx(take_idx), .in_port(in_port), .ir_op(ir_op),
        .out_ports(out_ports)
    );

    // R8: no interrupt is taken while interrupts are disabled.
    a_r8_no_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !take);
endmodule

// File: tb/mcu_core_bench.sv
// Self-checking bench: a test program in the ROM image, a table of output
// expectations by executed-instruction index, then directed interrupt and reset tests.
module mcu_core_bench;
    import mcu_pkg::*;

    function automatic logic [15:0] enc(op_t o, logic [7:0] a);
        return {o, 3'b000, a};
    endfunction

    function automatic logic [1023:0] build_prog();
        logic [1023:0] p;
        p = '0;
        p[0*16 +: 16]  = enc(OP_LDI, 8'h5A);
        p[1*16 +: 16]  = enc(OP_OUT, 8'd0);
        p[2*16 +: 16]  = enc(OP_STA, 8'd3);
        p[3*16 +: 16]  = enc(OP_LDI, 8'hC8);
        p[4*16 +: 16]  = enc(OP_ADD, 8'd3);
        p[5*16 +: 16]  = enc(OP_OUT, 8'd0);
        p[6*16 +: 16]  = enc(OP_JC, 8'd8);
        p[7*16 +: 16]  = enc(OP_LDI, 8'hEE);
        p[8*16 +: 16]  = enc(OP_SUBI, 8'h22);
        p[9*16 +: 16]  = enc(OP_JZ, 8'd11);
        p[10*16 +: 16] = enc(OP_OUT, 8'd0);
        p[11*16 +: 16] = enc(OP_JNZ, 8'd13);
        p[12*16 +: 16] = enc(OP_ORI, 8'hF0);
        p[13*16 +: 16] = enc(OP_XORI, 8'hFF);
        p[14*16 +: 16] = enc(OP_OUT, 8'd1);
        p[15*16 +: 16] = enc(OP_NOT, 8'd0);
        p[16*16 +: 16] = enc(OP_ANDI, 8'h3C);
        p[17*16 +: 16] = enc(OP_OUT, 8'd0);
        p[18*16 +: 16] = enc(OP_SUBI, 8'h31);
        p[19*16 +: 16] = enc(OP_JNC, 8'd21);
        p[20*16 +: 16] = enc(OP_IN, 8'd0);
        p[21*16 +: 16] = enc(OP_OUT, 8'd1);
        p[22*16 +: 16] = enc(OP_LDA, 8'd3);
        p[23*16 +: 16] = enc(OP_OUT, 8'd0);
        p[24*16 +: 16] = enc(OP_JMP, 8'd24);
        for (int k = 0; k < 4; k++) begin
            p[(48 + 4*k)*16 +: 16] = enc(OP_LDI, 8'h80 + 8'(k));
            p[(49 + 4*k)*16 +: 16] = enc(OP_OUT, 8'd1);
            p[(50 + 4*k)*16 +: 16] = enc(OP_RETI, 8'd0);
        end
        return p;
    endfunction

    localparam logic [1023:0] PROG = build_prog();

    // Rows: {executed index, expected out0, expected out1}
    localparam int NROWS = 7;
    localparam logic [23:0] TABLE [NROWS] = '{
        {8'd1,  8'h5A, 8'h00},   // R3 LDI then OUT; R1 due at edge 8
        {8'd5,  8'h22, 8'h00},   // R4 ADD wraps 0xC8+0x5A, sets carry
        {8'd9,  8'h22, 8'h00},   // R6 JC and JZ taken, skipped OUT has no effect
        {8'd12, 8'h22, 8'h0F},   // R5 ORI, XORI, OUT to register 1
        {8'd15, 8'h30, 8'h0F},   // R5 NOT, ANDI
        {8'd19, 8'h30, 8'hA7},   // R4 SUBI borrow so JNC falls through; R3 IN
        {8'd21, 8'h5A, 8'hA7}    // R3 STA then LDA from RAM
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_port = 8'hA7;
    logic [3:0]  irq = 4'b0;
    logic [15:0] out_ports;
    int          edges = 0;
    int          cycles = 0;
    int          n_tests = 0;
    int          n_fail = 0;

    mcu_core #(.ROM_IMAGE(PROG)) u_mcu_core (
        .clk(clk), .rst_n(rst_n), .in_port(in_port), .irq(irq), .out_ports(out_ports)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (rst_n) edges++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected under 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_edges(int n);
        while (edges < n) @(negedge clk);
    endtask

    task automatic wait_out1_change(logic [7:0] old);
        for (int i = 0; i < 80; i++) begin
            if (out_ports[15:8] != old) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2 outputs cleared in reset", out_ports, 16'h0000);
        rst_n = 1'b1;
        // R1: result of instruction 1 must not show before edge 8
        wait_edges(7);
        check("R1 no early result", out_ports, 16'h0000);
        for (int r = 0; r < NROWS; r++) begin
            wait_edges(4 * (int'(TABLE[r][23:16]) + 1));
            check($sformatf("R1 table row %0d", r), out_ports,
                  {TABLE[r][7:0], TABLE[r][15:8]});
        end
        // R7: lines 1 and 2 together, line 1 wins
        wait_edges(4 * 23);
        irq = 4'b0110;
        wait_out1_change(8'hA7);
        check("R7 priority line 1", {8'h00, out_ports[15:8]}, 16'h0081);
        irq[1] = 1'b0;
        // R8: RETI re-enables, pending line 2 then taken
        wait_out1_change(8'h81);
        check("R8 unmask after RETI", {8'h00, out_ports[15:8]}, 16'h0082);
        irq[2] = 1'b0;
        // R8: line 3 held high still reaches its OUT (no re-entry)
        irq[3] = 1'b1;
        wait_out1_change(8'h82);
        check("R8 masked while in service", {8'h00, out_ports[15:8]}, 16'h0083);
        irq = 4'b0;
        repeat (40) @(negedge clk);
        check("R8 return to main loop", out_ports, 16'h835A);
        // R7: lowest line wins when all four are raised
        irq = 4'b1111;
        wait_out1_change(8'h83);
        check("R7 line 0 highest", {8'h00, out_ports[15:8]}, 16'h0080);
        irq = 4'b0;
        repeat (40) @(negedge clk);
        // R2: reset in mid-run clears outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 reset mid-run", out_ports, 16'h0000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule